// File: doc/BRIEF.md
# Power-Fail Output Sequencer

This block sequences a group of supervisor power-fail outputs. Each output is derived from a digitized comparator result that reports whether its monitored input is below the power-fail threshold. During normal operation an output follows its comparator: it is low while the input is below threshold and high otherwise. When the supply is lost or the device runs from its backup battery, every output is forced low and the comparator results are ignored.

When the supply comes back, the outputs are held high for a recovery window. The comparator results have no effect during this window. The window is measured in ticks of a slow timebase, and a single configuration bit picks one of two lengths. After the window ends, each output tracks its own comparator again. For every output the block provides a level and a drive enable. A mode bit chooses push-pull drive, where the enable is always on, or open-drain drive, where the enable is on only to pull the pin low.

The comparators, the reference, the pads and the timebase are outside the block. All logic runs on one clock, and the tick is a single-cycle enable on that clock.

Top module: `pfo_sequencer`

## Requirements
- R1: In the tracking state, each output level is the inverse of its comparator bit, where comparator bit 1 means the input is below threshold. A comparator change reaches the level on the third rising clock edge after the edge that first samples it.
- R2: While `supply_ok` is 0 or `on_battery` is 1, the sequencer is in the down state. In that state every level is 0 and the comparator bits have no effect. Levels read 0 from the second rising edge after the power loss is sampled.
- R3: When the supply returns (`supply_ok` is 1 and `on_battery` is 0), the sequencer enters the recovery window. Throughout the window every level is 1, whatever the comparators report.
- R4: The window ends on the tick that completes its count. From then on, each level follows its own comparator as in R1.
- R5: With `open_drain` at 1, each enable is the inverse of its level, so a high level is released. With `open_drain` at 0, every enable is 1.
- R6: `long_window` at 0 selects SHORT_TICKS ticks and at 1 selects LONG_TICKS ticks. The choice is latched when the window starts, so changing `long_window` during the window has no effect.
- R7: Losing power during the window aborts it and returns the block to the down state. The next return starts a fresh window of the full length.
- R8: While reset is asserted, every level and every enable is 0 and the sequencer is in the down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle slow timebase pulse |
| supply_ok | input | 1 | Supply is above the upper deselect threshold |
| on_battery | input | 1 | Device is running from its backup battery |
| long_window | input | 1 | Recovery window select: 0 short, 1 long |
| open_drain | input | 1 | Drive style: 1 open-drain, 0 push-pull |
| cmp_below | input | NUM_OUT | Raw comparator results, 1 = input below threshold |
| pf_level | output | NUM_OUT | Power-fail output levels |
| pf_oe | output | NUM_OUT | Per-output drive enables |

## Verification
The bench builds the block with SHORT_TICKS=4 and LONG_TICKS=9 and raises a tick every third clock. With these values both window lengths, a window aborted partway through, and a select change in mid-window all complete within a few dozen cycles. The distinct lengths show which count was latched. A behavioural model predicts level and enable on every clock, including the three-edge comparator latency, while the comparator patterns cycle through all combinations in both drive modes.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

    typedef enum logic [1:0] {
        PF_DOWN    = 2'd0,
        PF_RECOVER = 2'd1,
        PF_TRACK   = 2'd2
    } pf_mode_e;

    typedef struct packed {
        logic level;
        logic oe;
    } pf_drive_t;

endpackage

// File: rtl/pfo_sync.sv
module pfo_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;

endmodule

// File: rtl/pfo_recovery_ctrl.sv
module pfo_recovery_ctrl
    import pfo_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 96,
    parameter int unsigned LONG_TICKS  = 160,
    localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     supply_ok,
    input  logic     on_battery,
    input  logic     long_window,
    output pf_mode_e mode_o
);

    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_TICKS);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_TICKS);

    typedef struct packed {
        pf_mode_e         mode;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  power_up;

    assign power_up = supply_ok && !on_battery;

    always_comb begin
        r_d = r_q;
        unique case (r_q.mode)
            PF_DOWN: begin
                if (power_up) begin
                    r_d.mode = PF_RECOVER;
                    r_d.cnt  = long_window ? LONG_C : SHORT_C;
                end
            end
            PF_RECOVER: begin
                if (!power_up) begin
                    r_d.mode = PF_DOWN;
                    r_d.cnt  = '0;
                end else if (tick) begin
                    if (r_q.cnt <= CNT_W'(1)) begin
                        r_d.mode = PF_TRACK;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
            end
            PF_TRACK: begin
                if (!power_up) r_d.mode = PF_DOWN;
            end
            default: begin
                r_d.mode = PF_DOWN;
                r_d.cnt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= PF_DOWN;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o = r_q.mode;

    AST_POWER_LOSS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up |=> r_q.mode == PF_DOWN); // R2
    AST_WINDOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == PF_RECOVER && !supply_ok) |=> r_q.mode == PF_DOWN); // R7
    AST_WINDOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == PF_DOWN && power_up) |=>
        (r_q.cnt == ($past(long_window) ? LONG_C : SHORT_C))); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.mode == PF_RECOVER |-> (r_q.cnt != '0 && r_q.cnt <= LONG_C)); // R6
    AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == PF_RECOVER && power_up && !tick) |=> r_q.mode == PF_RECOVER); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == PF_RECOVER && power_up && !tick) |=> $stable(r_q.cnt)); // R6

endmodule

// File: rtl/pfo_out_stage.sv
module pfo_out_stage
    import pfo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pf_mode_e mode_i,
    input  logic     below_i,
    input  logic     open_drain_i,
    output logic     level_o,
    output logic     oe_o
);

    pf_drive_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        unique case (mode_i)
            PF_DOWN:    d_d.level = 1'b0;
            PF_RECOVER: d_d.level = 1'b1;
            PF_TRACK:   d_d.level = !below_i;
            default:    d_d.level = 1'b0;
        endcase
        d_d.oe = open_drain_i ? !d_d.level : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign level_o = d_q.level;
    assign oe_o    = d_q.oe;

    AST_TRACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == PF_TRACK |=> level_o == !$past(below_i)); // R1
    AST_PUSH_PULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !open_drain_i |=> oe_o); // R5

endmodule

// File: rtl/pfo_sequencer.sv
module pfo_sequencer
    import pfo_pkg::*;
#(
    parameter int unsigned NUM_OUT     = 2,
    parameter int unsigned SHORT_TICKS = 96,
    parameter int unsigned LONG_TICKS  = 160
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               supply_ok,
    input  logic               on_battery,
    input  logic               long_window,
    input  logic               open_drain,
    input  logic [NUM_OUT-1:0] cmp_below,
    output logic [NUM_OUT-1:0] pf_level,
    output logic [NUM_OUT-1:0] pf_oe
);

    logic [NUM_OUT-1:0] below_sync;
    pf_mode_e           mode;

    pfo_sync #(
        .WIDTH(NUM_OUT)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_below),
        .sync_o (below_sync)
    );

    pfo_recovery_ctrl #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .supply_ok  (supply_ok),
        .on_battery (on_battery),
        .long_window(long_window),
        .mode_o     (mode)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pfo_out_stage u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode),
            .below_i     (below_sync[g]),
            .open_drain_i(open_drain),
            .level_o     (pf_level[g]),
            .oe_o        (pf_oe[g])
        );

        AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(open_drain) |-> (pf_oe[g] == !pf_level[g])); // R5
    end

    AST_DOWN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PF_DOWN |=> pf_level == '0); // R2
    AST_RECOVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode == PF_RECOVER |=> pf_level == '1); // R3

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (mode == PF_DOWN); // R8
        end
    end

endmodule

// File: tb/pfo_sequencer_tb_top.sv
module pfo_sequencer_tb_top;

    localparam int NUM_OUT = 2;
    localparam int SHORT_T = 4;
    localparam int LONG_T  = 9;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic               supply_ok = 1'b0;
    logic               on_battery = 1'b1;
    logic               long_window = 1'b0;
    logic               open_drain = 1'b0;
    logic [NUM_OUT-1:0] cmp_below = '0;
    logic [NUM_OUT-1:0] pf_level;
    logic [NUM_OUT-1:0] pf_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfo_sequencer #(
        .NUM_OUT    (NUM_OUT),
        .SHORT_TICKS(SHORT_T),
        .LONG_TICKS (LONG_T)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .supply_ok  (supply_ok),
        .on_battery (on_battery),
        .long_window(long_window),
        .open_drain (open_drain),
        .cmp_below  (cmp_below),
        .pf_level   (pf_level),
        .pf_oe      (pf_oe)
    );

    // Reference model: phase 0 down, 1 window, 2 tracking
    int                 m_phase = 0;
    int                 m_left = 0;
    logic [NUM_OUT-1:0] cmp_q[$];
    logic [NUM_OUT-1:0] exp_level = '0;
    logic [NUM_OUT-1:0] exp_oe = '0;
    int                 exp_phase_out = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_left = 0;
            cmp_q.delete();
            cmp_q.push_back('0);
            cmp_q.push_back('0);
            exp_level = '0;
            exp_oe = '0;
            exp_phase_out = 0;
        end else begin
            logic [NUM_OUT-1:0] seen;
            seen = cmp_q.pop_front();
            exp_phase_out = m_phase;
            if (m_phase == 0)      exp_level = '0;
            else if (m_phase == 1) exp_level = '1;
            else                   exp_level = ~seen;
            exp_oe = open_drain ? ~exp_level : '1;
            cmp_q.push_back(cmp_below);
            if (!supply_ok || on_battery) begin
                m_phase = 0;
            end else if (m_phase == 0) begin
                m_phase = 1;
                m_left = long_window ? LONG_T : SHORT_T;
            end else if (m_phase == 1 && tick) begin
                m_left--;
                if (m_left == 0) m_phase = 2;
            end
        end
    end

    task automatic check(input string req, input logic [NUM_OUT-1:0] act,
                         input logic [NUM_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string rq;
            if (!rst_n)                  rq = "R8";
            else if (exp_phase_out == 0) rq = "R2";
            else if (exp_phase_out == 1) rq = "R3";
            else                         rq = "R1";
            check({rq, " level"}, pf_level, exp_level);
            check("R5 enable", pf_oe, exp_oe);
        end
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            tick <= (ph == 0);
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        int left = n;
        while (left > 0) begin
            @(posedge clk);
            if (tick) left--;
        end
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        clocks(3);
        check("R8 reset level", pf_level, '0);
        check("R8 reset enable", pf_oe, '0);
        rst_n = 1'b1;
        // down state ignores comparators (R2)
        for (int i = 0; i < 4; i++) begin
            cmp_below = NUM_OUT'(i);
            clocks(3);
            check("R2 down ignores cmp", pf_level, '0);
        end
        // return with short window, comparators all below (R3)
        cmp_below = '1;
        supply_ok = 1'b1;
        on_battery = 1'b0;
        clocks(3);
        check("R3 window forced high", pf_level, '1);
        wait_ticks(SHORT_T);
        clocks(4);
        check("R4 tracking after window", pf_level, '0);
        // comparator patterns, push-pull then open-drain (R1, R5)
        for (int m = 0; m < 2; m++) begin
            open_drain = m[0];
            for (int i = 0; i < 4; i++) begin
                cmp_below = NUM_OUT'(i);
                clocks(4);
                check("R1 track pattern", pf_level, ~NUM_OUT'(i));
                check("R5 drive mode", pf_oe, m[0] ? NUM_OUT'(i) : '1);
            end
        end
        // battery backup drops outputs (R2)
        on_battery = 1'b1;
        clocks(3);
        check("R2 battery low", pf_level, '0);
        // long window, select changed mid-window (R6)
        cmp_below = '1;
        long_window = 1'b1;
        on_battery = 1'b0;
        clocks(1);
        long_window = 1'b0;
        wait_ticks(SHORT_T + 2);
        check("R6 latched long window", pf_level, '1);
        wait_ticks(LONG_T);
        clocks(4);
        check("R6 long window ended", pf_level, '0);
        // abort during window then full restart (R7)
        supply_ok = 1'b0;
        clocks(4);
        supply_ok = 1'b1;
        wait_ticks(2);
        supply_ok = 1'b0;
        clocks(3);
        check("R7 abort low", pf_level, '0);
        supply_ok = 1'b1;
        wait_ticks(SHORT_T - 1);
        check("R7 fresh window high", pf_level, '1);
        wait_ticks(2);
        clocks(4);
        check("R7 window ended", pf_level, '0);
        // fast toggling comparator in tracking, open-drain
        open_drain = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cmp_below = NUM_OUT'(i * 3);
            clocks(1);
        end
        clocks(4);
        supply_ok = 1'b0;
        clocks(5);
        done = 1;
        summary();
    end

endmodule